// File: doc/BRIEF.md
# Four-Stage Watchdog Timer

The block is a watchdog that a system processor must service periodically. A small tick timer divides the block clock, which is taken to be the fixed 1 MHz reference, into ticks. It emits one tick per programmed number of cycles, either once or repeatedly. While the watchdog is armed, an 8-bit countdown decrements once per tick. Each time the countdown runs out, it reloads and a 2-bit stage counter advances.

On the fourth run-out the block raises a one-cycle system reset request, provided reset generation is enabled. The same event returns the block's own state to zero. The time left before that point, in ticks, is (3 − stage) × period + countdown.

Software talks to the block through a plain register port. A write takes one cycle. A read returns its data on the cycle after the request, flagged by a valid strobe. Software arms the watchdog, services it with a keepalive, reads the live countdown and stage, and clears the interrupt flag. Stopping the watchdog needs a 16-bit key written to a guard register just before the stop command.

Top module: `stage_watchdog`

## Requirements
- R1: After reset, every readable register (byte offsets 0x00, 0x04, 0x10) reads zero, and both `irq_o` and `sys_rst_o` are low.
- R2: The configuration register at 0x00 stores the source select in bits [3:0], the countdown period in bits [11:4], the interrupt enable in bit 12 and the reset enable in bit 15. All other bits read zero.
- R3: Writing bit 0 to the command register at 0x08 arms the watchdog, loads the countdown with the period and clears the stage. The status register at 0x04 shows the armed flag in bit 0, the countdown in bits [11:4], the stage in bits [13:12] and the interrupt flag in bit 14.
- R4: Each tick while armed decrements the countdown. A tick that finds the countdown at 1 or 0 reloads it with the period and advances the stage by one.
- R5: A start command while armed acts as the keepalive: it reloads the countdown, clears the stage and leaves the interrupt flag unchanged.
- R6: With the interrupt enable set, each of the first three run-outs sets the interrupt flag, which drives `irq_o`. The flag holds until a write to 0x04 with bit 14 set clears it. With the interrupt enable clear, run-outs never set it.
- R7: The fourth run-out, with the reset enable set, drives `sys_rst_o` high for exactly one cycle and returns configuration, status and timer registers to zero.
- R8: With the reset enable clear, the fourth run-out gives no reset pulse. The stage wraps to 0, the countdown reloads and the watchdog stays armed.
- R9: A stop command (bit 1 at 0x08) takes effect only if the previous register write was 0xC45A in bits [15:0] at the guard register 0x0C. Otherwise it is ignored and counting continues. A guard write with any other value leaves the block locked.
- R10: Any write to the command register consumes an earlier guard unlock, whatever value that write carries.
- R11: A stopped watchdog keeps its countdown and stage unchanged while ticks occur.
- R12: The timer register at 0x10 holds enable in bit 31, repeat mode in bit 30 and a cycle count in bits [28:0]. Writing it restarts the timer, which ticks after that many cycles. In one-shot mode it ticks once and then clears its enable bit. In repeat mode it ticks every that many cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, the 1 MHz reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| irq_o | output | 1 | Interrupt flag |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The checker assumes that a read and a write never arrive in the same cycle. It also assumes that a command write lands on the same byte offset that the decode expects, so a stop can only come from the command offset after a guard write. The interrupt-hold property assumes that the only clearing write is one to offset 0x04 with bit 14 set. The stimulus issues one register operation per cycle, never overlaps reads with writes, and drives the timer in one-shot mode for stepwise checks. This keeps every tick at a known point between register accesses.

// File: rtl/stage_watchdog.sv
module stage_watchdog #(
  parameter int          TMR_W      = 29,
  parameter int          ADDR_W     = 5,
  parameter logic [15:0] UNLOCK_KEY = 16'hC45A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int CNT_W = 8;
  localparam int EXP_W = 2;
  localparam logic [2:0] SEL_CFG = 3'd0;
  localparam logic [2:0] SEL_STS = 3'd1;
  localparam logic [2:0] SEL_CMD = 3'd2;
  localparam logic [2:0] SEL_KEY = 3'd3;
  localparam logic [2:0] SEL_TMR = 3'd4;
  localparam logic [EXP_W-1:0] LAST_STAGE = '1;

  logic [2:0] sel;
  assign sel = addr[4:2];

  logic wr_cfg, wr_sts, wr_cmd, wr_key, wr_tmr;
  assign wr_cfg = wr_en && sel == SEL_CFG;
  assign wr_sts = wr_en && sel == SEL_STS;
  assign wr_cmd = wr_en && sel == SEL_CMD;
  assign wr_key = wr_en && sel == SEL_KEY;
  assign wr_tmr = wr_en && sel == SEL_TMR;

  logic             tmr_en, tmr_rep;
  logic [TMR_W-1:0] tmr_per, tmr_cnt;
  logic             tick;

  logic [3:0]       cfg_src;
  logic [CNT_W-1:0] cfg_period;
  logic             cfg_irq_en, cfg_rst_en;

  logic             running, unlocked, irq_flag;
  logic [CNT_W-1:0] count;
  logic [EXP_W-1:0] exp_cnt;

  logic do_start, do_stop, cmd_hit, expire, fire;
  assign do_stop  = wr_cmd && wdata[1] && unlocked;
  assign do_start = wr_cmd && wdata[0] && !do_stop;
  assign cmd_hit  = do_start || do_stop;
  assign tick     = tmr_en && (tmr_per != '0) && (tmr_cnt == tmr_per - 1'b1);
  assign expire   = running && tick && (count <= CNT_W'(1)) && !cmd_hit;
  assign fire     = expire && (exp_cnt == LAST_STAGE) && cfg_rst_en;

  logic unused_bits;
  assign unused_bits = ^{wdata, addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_en <= 1'b0; tmr_rep <= 1'b0; tmr_per <= '0; tmr_cnt <= '0;
    end else if (fire) begin
      tmr_en <= 1'b0; tmr_rep <= 1'b0; tmr_per <= '0; tmr_cnt <= '0;
    end else if (wr_tmr) begin
      tmr_en  <= wdata[31];
      tmr_rep <= wdata[30];
      tmr_per <= wdata[TMR_W-1:0];
      tmr_cnt <= '0;
    end else if (tick) begin
      tmr_cnt <= '0;
      if (!tmr_rep) tmr_en <= 1'b0;
    end else if (tmr_en && tmr_per != '0) begin
      tmr_cnt <= tmr_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_src <= '0; cfg_period <= '0; cfg_irq_en <= 1'b0; cfg_rst_en <= 1'b0;
    end else if (fire) begin
      cfg_src <= '0; cfg_period <= '0; cfg_irq_en <= 1'b0; cfg_rst_en <= 1'b0;
    end else if (wr_cfg) begin
      cfg_src    <= wdata[3:0];
      cfg_period <= wdata[11:4];
      cfg_irq_en <= wdata[12];
      cfg_rst_en <= wdata[15];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; count <= '0; exp_cnt <= '0;
    end else if (fire) begin
      running <= 1'b0; count <= '0; exp_cnt <= '0;
    end else if (do_stop) begin
      running <= 1'b0;
    end else if (do_start) begin
      running <= 1'b1;
      count   <= cfg_period;
      exp_cnt <= '0;
    end else if (expire) begin
      count   <= cfg_period;
      exp_cnt <= exp_cnt + 1'b1;
    end else if (running && tick) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       unlocked <= 1'b0;
    else if (fire)    unlocked <= 1'b0;
    else if (wr_key)  unlocked <= (wdata[15:0] == UNLOCK_KEY);
    else if (wr_en)   unlocked <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                           irq_flag <= 1'b0;
    else if (fire)                                        irq_flag <= 1'b0;
    else if (expire && cfg_irq_en && exp_cnt != LAST_STAGE) irq_flag <= 1'b1;
    else if (wr_sts && wdata[14])                         irq_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_rst_o <= 1'b0;
    else        sys_rst_o <= fire;
  end

  assign irq_o = irq_flag;

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_CFG: rd_word = (32'(cfg_rst_en) << 15) | (32'(cfg_irq_en) << 12) |
                         (32'(cfg_period) << 4) | 32'(cfg_src);
      SEL_STS: rd_word = (32'(irq_flag) << 14) | (32'(exp_cnt) << 12) |
                         (32'(count) << 4) | 32'(running);
      SEL_TMR: rd_word = (32'(tmr_en) << 31) | (32'(tmr_rep) << 30) | 32'(tmr_per);
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0; rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end
endmodule

// File: rtl/stage_watchdog_checker.sv
module stage_watchdog_checker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              irq_o,
  input logic              sys_rst_o,
  input logic              running,
  input logic              unlocked,
  input logic [1:0]        exp_cnt,
  input logic              rst_en
);
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);

  a_r7_pulse_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(rst_en));

  a_r7_state_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (!running && exp_cnt == 2'd0 && !irq_o));

  a_r9_stop_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(unlocked) || sys_rst_o));

  a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(wr_en && addr[4:2] == 3'd1 && wdata[14])) |=> (irq_o || sys_rst_o));

  a_r4_stage_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exp_cnt) |-> (exp_cnt == 2'($past(exp_cnt) + 2'd1) || exp_cnt == 2'd0));
endmodule

bind stage_watchdog stage_watchdog_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq_o(irq_o), .sys_rst_o(sys_rst_o), .running(running),
  .unlocked(unlocked), .exp_cnt(exp_cnt), .rst_en(cfg_rst_en)
);

// File: tb/stage_watchdog_bench.sv
`timescale 1ns/1ps
module stage_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid, irq_o, sys_rst_o;

  always #4 clk = ~clk;

  stage_watchdog u_stage_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .irq_o(irq_o),
    .sys_rst_o(sys_rst_o)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  int pulses = 0, last_pulse = 0;
  bit wide = 1'b0, prev_rst = 1'b0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sys_rst_o) begin
      pulses++;
      last_pulse = cyc;
      if (prev_rst) wide = 1'b1;
    end
    prev_rst = sys_rst_o;
    if (rd_valid) begin
      if (q_exp.size() == 0) begin
        tests++; fails++;
        $display("FAIL unexpected read data %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        tests++;
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    while (q_exp.size() != 0) @(negedge clk);
  endtask

  task automatic one_tick();
    wr(5'h10, 32'h8000_0004);
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] sts(input bit run, input int cnt, input int stg, input bit irq);
    return (32'(irq) << 14) | (32'(stg) << 12) | (32'(cnt) << 4) | 32'(run);
  endfunction

  initial begin
    #(8 * 50000);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(5'h00, 32'h0, "R1 cfg");
    rd(5'h04, 32'h0, "R1 status");
    rd(5'h10, 32'h0, "R1 timer");
    check(32'(irq_o), 0, "R1 irq");
    check(32'(sys_rst_o), 0, "R1 reset out");
    // R2 field mask
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, 32'h0000_9FFF, "R2 cfg mask");
    wr(5'h00, 32'h0000_9035);
    rd(5'h00, 32'h0000_9035, "R2 cfg value");
    // R3 start
    wr(5'h08, 32'h1);
    rd(5'h04, sts(1, 3, 0, 0), "R3 start load");
    // R4 countdown and stage
    one_tick(); rd(5'h04, sts(1, 2, 0, 0), "R4 dec 1");
    one_tick(); rd(5'h04, sts(1, 1, 0, 0), "R4 dec 2");
    one_tick(); rd(5'h04, sts(1, 3, 1, 1), "R4 R6 first run-out");
    check(32'(irq_o), 1, "R6 irq set");
    // R5 keepalive
    wr(5'h08, 32'h1);
    rd(5'h04, sts(1, 3, 0, 1), "R5 keepalive");
    wr(5'h04, 32'h4000);
    rd(5'h04, sts(1, 3, 0, 0), "R6 irq cleared");
    check(32'(irq_o), 0, "R6 irq low");
    // R9 locked stop ignored
    wr(5'h08, 32'h2);
    rd(5'h04, sts(1, 3, 0, 0), "R9 stop without key");
    one_tick(); rd(5'h04, sts(1, 2, 0, 0), "R9 still counting");
    wr(5'h0C, 32'h1234);
    wr(5'h08, 32'h2);
    one_tick(); rd(5'h04, sts(1, 1, 0, 0), "R9 wrong key");
    // R10 key consumed by any command
    wr(5'h0C, 32'hC45A);
    wr(5'h08, 32'h1);
    wr(5'h08, 32'h2);
    rd(5'h04, sts(1, 3, 0, 0), "R10 key consumed");
    // R9 R11 proper stop, frozen
    wr(5'h0C, 32'hC45A);
    wr(5'h08, 32'h2);
    rd(5'h04, sts(0, 3, 0, 0), "R9 stop with key");
    one_tick(); rd(5'h04, sts(0, 3, 0, 0), "R11 frozen");
    // R8 no reset enable, R6 irq disabled
    wr(5'h00, 32'h0000_0020);
    wr(5'h08, 32'h1);
    rd(5'h04, sts(1, 2, 0, 0), "R8 armed");
    for (int i = 0; i < 6; i++) one_tick();
    rd(5'h04, sts(1, 2, 3, 0), "R8 stage three");
    check(32'(irq_o), 0, "R6 irq gated off");
    one_tick(); one_tick();
    rd(5'h04, sts(1, 2, 0, 0), "R8 wrap");
    check(32'(pulses), 0, "R8 no pulse");
    // R7 reset path, R12 one-shot
    wr(5'h00, 32'h0000_8010);
    wr(5'h08, 32'h1);
    rd(5'h04, sts(1, 1, 0, 0), "R7 armed");
    for (int i = 0; i < 3; i++) one_tick();
    rd(5'h04, sts(1, 1, 3, 0), "R7 stage three");
    rd(5'h10, 32'h0000_0004, "R12 one-shot cleared enable");
    one_tick();
    check(32'(pulses), 1, "R7 pulse count");
    check(32'(wide), 0, "R7 pulse width");
    rd(5'h00, 32'h0, "R7 cfg cleared");
    rd(5'h04, 32'h0, "R7 status cleared");
    rd(5'h10, 32'h0, "R7 timer cleared");
    // R12 repeat mode period
    wr(5'h00, 32'h0000_8010);
    wr(5'h08, 32'h1);
    begin
      int t0;
      @(negedge clk);
      t0 = cyc;
      wr_en = 1'b1; addr = 5'h10; wdata = 32'hC000_0005;
      @(negedge clk);
      wr_en = 1'b0;
      for (int i = 0; i < 60 && pulses < 2; i++) @(negedge clk);
      check(32'(pulses), 2, "R12 repeat pulse");
      check(32'(last_pulse - t0), 21, "R12 repeat tick spacing");
    end
    check(32'(wide), 0, "R7 second pulse width");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule